// File: doc/BRIEF.md
# Master-Mode Stereo Serial Audio Transmitter

This block is the output side of a stereo converter that owns the serial clocks. It derives a bit clock and a frame clock from its own clock and shifts out one 24-bit two's complement word per channel per frame, most significant bit first. The link runs in one of three speed classes, selected by a 2-bit code, and an optional pre-divide by two halves the master rate before anything else sees it. Every frame has 64 bit slots, 32 per channel. The format select places the data either left-justified or in I2S alignment.

The block runs from a core clock `clk2x_i` at twice the master-clock rate, so every output, including a bit clock equal to the master clock, is a plain register. One bit-clock half period lasts H core cycles. H is the master-to-bit-clock divide D (4, 2 and 1 for speed codes 00, 01 and 10) times the pre-divide P (2 when `pre_div_i` is 1, otherwise 1). With 64 bit clocks per frame, this gives the master-to-frame ratios of 256, 128 and 64.

Sample pairs enter through a valid/ready stream with a one-pair holding buffer. A pair is accepted on a clock edge where `smp_valid_i` and `smp_ready_o` are both high. The producer must hold `smp_valid_i` and both data words steady until that edge. `smp_ready_o` stays low from the accepting edge until the held pair moves into the serialiser at the start of the next left half frame. The configuration pins are sampled while reset is low. A reserved or changed configuration freezes the link until the next reset.

Top module: `audio_tx_master`

## Requirements
- R1: Each bit-clock level lasts exactly H core cycles, where H = D·P, D is 4, 2 or 1 for speed codes 00, 01 and 10, and P is 2 when `pre_div_i` = 1, otherwise 1.
- R2: Each frame-clock period spans 64 bit-clock periods: 32 in the left half and 32 in the right half. The frame clock changes only at the start of a half frame.
- R3: `fclk_o` and `sdata_o` change only in the core cycle where `bclk_o` falls from 1 to 0, so they are stable across every rising edge of `bclk_o`.
- R4: With `i2s_sel_i` = 0 (left-justified), the left half has `fclk_o` = 1 and the right half has `fclk_o` = 0. Each word's bit 23 occupies slot 0 of its half, and the bits follow down to bit 0 in slot 23.
- R5: With `i2s_sel_i` = 1 (I2S), the left half has `fclk_o` = 0 and the right half has `fclk_o` = 1. Slot 0 of each half carries 0, bit 23 occupies slot 1, and bit 0 occupies slot 24.
- R6: Every slot that carries no data bit is driven to 0.
- R7: A pair accepted by valid/ready is sent in the next frame whose left half starts after acceptance. `smp_ready_o` is low in the cycle after an acceptance. Pairs are sent in the order they were accepted.
- R8: If no pair is held when a left half starts, both channels of that frame carry all zeros.
- R9: With speed code 11 applied during reset, `bclk_o`, `fclk_o` and `sdata_o` stay static after reset.
- R10: If `pre_div_i`, `speed_i` or `i2s_sel_i` differs from its value during reset, `bclk_o`, `fclk_o` and `sdata_o` freeze within two core cycles and stay frozen until the next reset.
- R11: During reset, `bclk_o` = 0, `fclk_o` = the right-half level (0 left-justified, 1 I2S), `sdata_o` = 0 and `smp_ready_o` = 1. The first left half begins at the first falling edge of `bclk_o`, 2H core cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x_i | input | 1 | Core clock, twice the master-clock rate |
| rst_n_i | input | 1 | Synchronous active-low reset; configuration is sampled while low |
| pre_div_i | input | 1 | 1 halves the master rate before all other logic |
| speed_i | input | 2 | Speed code: 00 single, 01 double, 10 quad, 11 reserved |
| i2s_sel_i | input | 1 | 0 left-justified, 1 I2S alignment |
| smp_valid_i | input | 1 | Sample pair on the data inputs is valid |
| smp_ready_o | output | 1 | Holding buffer can accept a pair |
| smp_left_i | input | 24 | Left-channel word, two's complement |
| smp_right_i | input | 24 | Right-channel word, two's complement |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame clock, 50% duty, one period per sample pair |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
If the half-period counter or the speed decode is wrong, it shows on the very next bit-clock edge as a level that lasts the wrong number of core cycles. If the slot counter or the alignment offset is wrong, it shows within one frame: the received 64-bit pattern is shifted, or the frame clock changes after the wrong number of bits. A lost or stale holding buffer shows as the wrong word in the following frame, and a broken freeze shows as any output edge after the configuration changes. The receiving model samples on rising bit-clock edges, as a real receiver would, and rebuilds every bit of each frame.

// File: rtl/audio_ser_pkg.sv
package audio_ser_pkg;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_RSVD   = 2'b11
  } speed_e;

  typedef struct packed {
    logic   pre_div;
    speed_e speed;
    logic   i2s;
  } ser_cfg_t;

  localparam int unsigned MAX_HALF = 8;
  localparam int unsigned HCNT_W   = $clog2(MAX_HALF + 1);

  // core cycles per bit-clock level: master/bclk divide times pre-divide
  function automatic logic [HCNT_W-1:0] half_cycles(input ser_cfg_t c);
    logic [HCNT_W-1:0] d;
    case (c.speed)
      SPD_SINGLE: d = HCNT_W'(4);
      SPD_DOUBLE: d = HCNT_W'(2);
      default:    d = HCNT_W'(1);
    endcase
    return c.pre_div ? HCNT_W'(d << 1) : d;
  endfunction

endpackage

// File: rtl/ser_mode_lock.sv
module ser_mode_lock
  import audio_ser_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  ser_cfg_t          cfg_i,
  output ser_cfg_t          cfg_o,
  output logic              run_o,
  output logic [HCNT_W-1:0] half_o
);

  ser_cfg_t cfg_q;
  logic     halt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      cfg_q  <= cfg_i;
      halt_q <= 1'b0;
    end else if (cfg_i != cfg_q) begin
      halt_q <= 1'b1;
    end
  end

  assign cfg_o  = cfg_q;
  assign run_o  = !halt_q && (cfg_q.speed != SPD_RSVD);
  assign half_o = half_cycles(cfg_q);

  // R10
  cfg_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (cfg_i != cfg_q) |=> !run_o);

endmodule

// File: rtl/ser_bclk_gen.sv
module ser_bclk_gen #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          run_i,
  input  logic [CW-1:0] half_i,
  output logic          bclk_o,
  output logic          fall_o
);

  logic [CW-1:0] cnt_q;
  logic          bclk_q;
  logic          wrap;

  assign wrap = run_i && (cnt_q == half_i - CW'(1));

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (run_i) begin
      if (wrap) begin
        cnt_q  <= '0;
        bclk_q <= ~bclk_q;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign bclk_o = bclk_q;
  assign fall_o = wrap && bclk_q;

  // R9 R10
  hold_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !run_i |=> $stable(bclk_q));

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    run_i |-> (cnt_q < half_i));

endmodule

// File: rtl/ser_frame_shift.sv
module ser_frame_shift #(
  parameter int unsigned SMP_W      = 24,
  parameter int unsigned HALF_SLOTS = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_n_i,
  input  logic                      fall_i,
  input  logic                      i2s_i,
  input  logic                      smp_valid_i,
  output logic                      smp_ready_o,
  input  logic [1:0][SMP_W-1:0]     smp_i,
  output logic                      fclk_o,
  output logic                      sdata_o
);

  localparam int unsigned SLOT_W = $clog2(2 * HALF_SLOTS);
  localparam int unsigned HS_W   = SLOT_W - 1;
  localparam int unsigned IDX_W  = $clog2(SMP_W);
  localparam logic [HS_W:0] LIM  = (HS_W+1)'(SMP_W);

  logic [SLOT_W-1:0] slot_q, slot_n;
  logic              buf_full_q, take, frame_start, right_half;
  logic              fclk_q, sdata_q, bit_n;
  logic [HS_W:0]     rel;
  logic [IDX_W-1:0]  idx;
  logic [SMP_W-1:0]  word_sel;

  assign slot_n      = slot_q + SLOT_W'(1);
  assign right_half  = slot_n[SLOT_W-1];
  assign frame_start = fall_i && (slot_n == '0);
  assign take        = smp_valid_i && !buf_full_q;
  assign smp_ready_o = !buf_full_q;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [SMP_W-1:0] buf_q, cur_q, word_n;
    assign word_n = frame_start ? (buf_full_q ? buf_q : '0) : cur_q;
    always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
        buf_q <= '0;
        cur_q <= '0;
      end else begin
        if (take)   buf_q <= smp_i[ch];
        if (fall_i) cur_q <= word_n;
      end
    end
  end

  assign word_sel = right_half ? g_chan[1].word_n : g_chan[0].word_n;
  assign rel      = {1'b0, slot_n[HS_W-1:0]} - {{HS_W{1'b0}}, i2s_i};
  assign idx      = IDX_W'(SMP_W - 1) - rel[IDX_W-1:0];
  assign bit_n    = (rel < LIM) ? word_sel[idx] : 1'b0;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      slot_q     <= '1;
      fclk_q     <= i2s_i;
      sdata_q    <= 1'b0;
      buf_full_q <= 1'b0;
    end else begin
      if (frame_start && buf_full_q) buf_full_q <= 1'b0;
      else if (take)                 buf_full_q <= 1'b1;
      if (fall_i) begin
        slot_q  <= slot_n;
        fclk_q  <= ~right_half ^ i2s_i;
        sdata_q <= bit_n;
      end
    end
  end

  assign fclk_o  = fclk_q;
  assign sdata_o = sdata_q;

  // R3
  edge_align_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !fall_i |=> ($stable(fclk_q) && $stable(sdata_q)));

  // R2
  half_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $changed(fclk_q) |-> (slot_q[HS_W-1:0] == '0));

  // R6
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ({1'b0, slot_q[HS_W-1:0]} > LIM) |-> !sdata_q);

  // R7
  accept_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (smp_valid_i && smp_ready_o) |=> !smp_ready_o);

endmodule

// File: rtl/audio_tx_master.sv
module audio_tx_master
  import audio_ser_pkg::*;
#(
  parameter int unsigned SMP_W      = 24,
  parameter int unsigned HALF_SLOTS = 32
) (
  input  logic             clk2x_i,
  input  logic             rst_n_i,
  input  logic             pre_div_i,
  input  logic [1:0]       speed_i,
  input  logic             i2s_sel_i,
  input  logic             smp_valid_i,
  output logic             smp_ready_o,
  input  logic [SMP_W-1:0] smp_left_i,
  input  logic [SMP_W-1:0] smp_right_i,
  output logic             bclk_o,
  output logic             fclk_o,
  output logic             sdata_o
);

  ser_cfg_t            cfg_in, cfg_q;
  logic                run, fall;
  logic [HCNT_W-1:0]   half;
  logic [1:0][SMP_W-1:0] smp_pair;

  assign cfg_in   = '{pre_div: pre_div_i, speed: speed_e'(speed_i), i2s: i2s_sel_i};
  assign smp_pair = {smp_right_i, smp_left_i};

  ser_mode_lock u_lock (
    .clk_i   (clk2x_i),
    .rst_n_i (rst_n_i),
    .cfg_i   (cfg_in),
    .cfg_o   (cfg_q),
    .run_o   (run),
    .half_o  (half)
  );

  ser_bclk_gen #(.CW(HCNT_W)) u_bclk (
    .clk_i   (clk2x_i),
    .rst_n_i (rst_n_i),
    .run_i   (run),
    .half_i  (half),
    .bclk_o  (bclk_o),
    .fall_o  (fall)
  );

  ser_frame_shift #(.SMP_W(SMP_W), .HALF_SLOTS(HALF_SLOTS)) u_frame (
    .clk_i       (clk2x_i),
    .rst_n_i     (rst_n_i),
    .fall_i      (fall),
    .i2s_i       (cfg_q.i2s),
    .smp_valid_i (smp_valid_i),
    .smp_ready_o (smp_ready_o),
    .smp_i       (smp_pair),
    .fclk_o      (fclk_o),
    .sdata_o     (sdata_o)
  );

endmodule

// File: tb/audio_tx_master_tb_top.sv
module audio_tx_master_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pre_div = 1'b0;
  logic [1:0]  speed = 2'b00;
  logic        i2s_sel = 1'b0;
  logic        valid = 1'b0;
  logic [23:0] left_w = '0, right_w = '0;
  wire         ready, bclk, fclk, sdata;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  audio_tx_master dut_i (
    .clk2x_i(clk), .rst_n_i(rst_n), .pre_div_i(pre_div), .speed_i(speed),
    .i2s_sel_i(i2s_sel), .smp_valid_i(valid), .smp_ready_o(ready),
    .smp_left_i(left_w), .smp_right_i(right_w),
    .bclk_o(bclk), .fclk_o(fclk), .sdata_o(sdata));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] gen_l(input int j, input int c);
    case (j)
      0: return 24'h800000;
      1: return 24'h7FFFFF;
      2: return 24'h000001;
      default: return 24'(j * 32'h3A5C17 + c * 32'h0F1E2D + 32'h123456);
    endcase
  endfunction

  function automatic logic [23:0] gen_r(input int j, input int c);
    case (j)
      0: return 24'hFFFFFF;
      1: return 24'h800001;
      default: return ~24'(j * 32'h2B1D09 + c * 32'h050607 + 32'h00ABCD);
    endcase
  endfunction

  function automatic logic [63:0] exp_frame(input logic [23:0] l, input logic [23:0] r, input logic fmt);
    logic [63:0] f;
    f = '0;
    for (int p = 0; p < 64; p++) begin
      int s;
      int k;
      s = p % 32;
      k = s - (fmt ? 1 : 0);
      if (k >= 0 && k < 24) f[63-p] = (p < 32) ? l[23-k] : r[23-k];
    end
    return f;
  endfunction

  function automatic int half_of(input logic pd, input logic [1:0] spd);
    int d;
    d = (spd == 2'b00) ? 4 : (spd == 2'b01) ? 2 : 1;
    return pd ? 2 * d : d;
  endfunction

  task automatic do_reset(input logic pd, input logic [1:0] spd, input logic fmt);
    @(negedge clk);
    rst_n = 1'b0; valid = 1'b0;
    pre_div = pd; speed = spd; i2s_sel = fmt;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(bclk == 1'b0,  "R11 bclk in reset", 64'(bclk), 64'd0);
    chk(fclk == fmt,   "R11 fclk in reset", 64'(fclk), 64'(fmt));
    chk(sdata == 1'b0, "R11 sdata in reset", 64'(sdata), 64'd0);
    chk(ready == 1'b1, "R11 ready in reset", 64'(ready), 64'd1);
  endtask

  // reset, stream nfeed pairs, decode nframes frames on rising bclk
  task automatic run_cfg(input logic pd, input logic [1:0] spd, input logic fmt,
                         input int nfeed, input int nframes, input int cidx);
    int h, ctr, pos, frame, fidx, limit;
    logic pb, pf, ps, prf, lvl, hs;
    logic [63:0] rx;
    do_reset(pd, spd, fmt);
    h = half_of(pd, spd);
    lvl = ~fmt;
    fidx = 0;
    if (nfeed > 0) begin
      valid = 1'b1; left_w = gen_l(0, cidx); right_w = gen_r(0, cidx);
    end
    hs = valid && ready;
    rst_n = 1'b1;
    pb = 1'b0; pf = fmt; ps = 1'b0; prf = fmt;
    ctr = 0; pos = -1; frame = 0; rx = '0;
    limit = 128 * h * (nframes + 2);
    for (int cyc = 0; cyc < limit && frame < nframes; cyc++) begin
      @(negedge clk);
      ctr++;
      if (bclk != pb) begin
        // R1 level length
        chk(ctr == h, "R1 bclk level length", 64'(ctr), 64'(h));
        ctr = 0;
      end
      if ((fclk != pf || sdata != ps) && !(pb == 1'b1 && bclk == 1'b0))
        chk(1'b0, "R3 fclk/sdata moved off falling bclk", {fclk, sdata}, {pf, ps});
      if (pb == 1'b0 && bclk == 1'b1) begin
        if (fclk != prf && fclk == lvl) begin
          if (pos >= 0) chk(pos == 63, "R2 frame length", 64'(pos + 1), 64'd64);
          pos = 0;
        end else if (pos >= 0) begin
          pos++;
          if (fclk != prf) chk(pos == 32, "R2 half length", 64'(pos), 64'd32);
        end
        prf = fclk;
        if (pos >= 0) begin
          rx[63-pos] = sdata;
          if (pos == 63) begin
            logic [63:0] ef;
            ef = (frame < nfeed) ? exp_frame(gen_l(frame, cidx), gen_r(frame, cidx), fmt) : '0;
            // R4 R5 R6 R7 R8 whole frame contents
            chk(rx == ef, fmt ? "R5 R6 R7 R8 I2S frame" : "R4 R6 R7 R8 LJ frame", rx, ef);
            frame++;
          end
        end
      end
      pb = bclk; pf = fclk; ps = sdata;
      if (hs) begin
        // R7 ready drops after acceptance
        chk(ready == 1'b0, "R7 ready after accept", 64'(ready), 64'd0);
        fidx++;
        if (fidx < nfeed) begin
          left_w = gen_l(fidx, cidx); right_w = gen_r(fidx, cidx);
        end else valid = 1'b0;
      end
      hs = valid && ready;
    end
    chk(frame == nframes, "R2 frames decoded", 64'(frame), 64'(nframes));
    valid = 1'b0;
  endtask

  task automatic expect_frozen(input int cycles, input string req);
    logic b0, f0, s0;
    bit moved;
    b0 = bclk; f0 = fclk; s0 = sdata; moved = 1'b0;
    repeat (cycles) begin
      @(negedge clk);
      if (bclk != b0 || fclk != f0 || sdata != s0) moved = 1'b1;
    end
    chk(!moved, req, {bclk, fclk, sdata}, {b0, f0, s0});
  endtask

  initial begin
    // sweep every valid speed code, pre-divide and format
    for (int pd = 0; pd < 2; pd++)
      for (int spd = 0; spd < 3; spd++)
        for (int fm = 0; fm < 2; fm++) begin
          int c;
          c = pd * 6 + spd * 2 + fm;
          // odd configs stop feeding early to exercise R8
          run_cfg(1'(pd), 2'(spd), 1'(fm), (c % 2) ? 3 : 5, 5, c);
        end

    // R9 reserved speed code
    do_reset(1'b0, 2'b11, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    expect_frozen(300, "R9 reserved code static");

    // R10 speed change mid-stream, then restart after reset
    do_reset(1'b0, 2'b01, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    repeat (700) @(negedge clk);
    speed = 2'b00;
    repeat (2) @(negedge clk);
    expect_frozen(400, "R10 speed change freezes");

    // R10 format change
    do_reset(1'b1, 2'b10, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (333) @(negedge clk);
    i2s_sel = 1'b1;
    repeat (2) @(negedge clk);
    expect_frozen(200, "R10 format change freezes");

    run_cfg(1'b0, 2'b10, 1'b0, 3, 3, 20);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL R2 watchdog expired actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule